// File: doc/BRIEF.md
# Buffered capture/compare timer channel

A 16-bit up-counter paired with a single register that changes role with the operating mode. In five compare modes the register holds a compare value. The comparison uses a shadow buffer behind the register, so software can rewrite the register at any moment and the change takes effect only at a safe point. That point is either the next counter clear, or the first clear after an arming write to a second register address. A match raises a one-cycle interrupt, clears the counter, and may toggle an output pin.

In two capture modes the same register latches the running count on a selected edge of a synchronized capture pin. In pulse-width mode the counter is also cleared at that edge. The counter advances on a single-cycle clock enable, or in event mode on rising edges of an external event input. Disabling the channel holds the counter at zero. It keeps a compare value but wipes a captured one.

Top module: `cct_timer`

## Requirements
- R1: After reset, count_q, rd_data, cmp_irq, cap_irq and tmr_out are all 0.
- R2: In compare modes (mode 0 interval, 1 event, 2 triggered pulse, 3 one-shot, 4 PWM) the counter advances by one per tick and, on a tick at which it equals the buffer value B, clears to 0x0000 instead; the period is B+1 ticks.
- R3: A match produces cmp_irq high for exactly the following cycle; tmr_out inverts on a match when out_en=1 and never changes otherwise.
- R4: While tmr_en=0 the counter is held at 0, and a compare write (wr_en=1, wr_sel=0) loads both the register and the buffer.
- R5: In modes 0, 1 and 3 a running compare write updates rd_data at once, but the match keeps using the old buffer until the next counter clear, which copies the register into the buffer.
- R6: In modes 2 and 4 the buffer reloads only at the first counter clear after an arming write (wr_en=1, wr_sel=1); that reload consumes the arm, so later clears do not reload without a new arming write.
- R7: In mode 1 the counter ticks once per synchronized rising edge of evt_in, and cyc_tick has no effect; in all other modes it ticks on cyc_tick.
- R8: In mode 3 the counter stops at 0 after its first match and stays there until tmr_en is dropped and raised again.
- R9: cap_in passes through a two-flop synchronizer; cap_edge_sel selects 01 rising, 10 falling, 11 both, 00 none; each detected edge gives exactly one capture, on the third clock edge after the pin changes.
- R10: In mode 5 (free-running) the counter wraps modulo 2^16; a capture copies the count into the register without disturbing the counter and pulses cap_irq for one cycle.
- R11: In mode 6 (pulse width) a capture copies the count and clears the counter to 0x0000 in the same cycle.
- R12: With tmr_en=0 the register is cleared in modes 5 and 6 and keeps its value in compare modes.
- R13: In modes 5 and 6 compare writes are ignored; rd_data always returns the whole current register value, the old one until the capturing edge and the new one after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en | input | 1 | Counter run enable |
| mode | input | 3 | Operating mode, 0 to 6 |
| cyc_tick | input | 1 | Count clock enable |
| evt_in | input | 1 | External event input (mode 1) |
| cap_in | input | 1 | Capture trigger pin |
| cap_edge_sel | input | 2 | Capture edge selection |
| out_en | input | 1 | Timer output toggle enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: compare register, 1: second register (arming strobe) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Capture/compare register contents |
| count_q | output | 16 | Current counter value |
| cmp_irq | output | 1 | Compare match interrupt pulse |
| cap_irq | output | 1 | Capture interrupt pulse |
| tmr_out | output | 1 | Toggling timer output |

## Verification
The bench builds the channel with CNT_W=16 and SYNC_STAGES=2, the default values. Compare values of 2 to 9 keep every period short, so many reload boundaries fit in a short run. The two-stage synchronizer fixes capture latency at three edges, which lets the bench predict each captured count exactly from the counter value it samples.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam logic [2:0] MODE_INTERVAL = 3'd0;
  localparam logic [2:0] MODE_EVENT    = 3'd1;
  localparam logic [2:0] MODE_TRIGPLS  = 3'd2;
  localparam logic [2:0] MODE_ONESHOT  = 3'd3;
  localparam logic [2:0] MODE_PWM      = 3'd4;
  localparam logic [2:0] MODE_FREERUN  = 3'd5;
  localparam logic [2:0] MODE_PWIDTH   = 3'd6;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  function automatic logic is_capture(input logic [2:0] m);
    return (m == MODE_FREERUN) || (m == MODE_PWIDTH);
  endfunction

  function automatic logic is_batch(input logic [2:0] m);
    return (m == MODE_TRIGPLS) || (m == MODE_PWM);
  endfunction

  function automatic logic edge_hit(input logic [1:0] sel, input logic cur, input logic prev);
    return (sel[0] && cur && !prev) || (sel[1] && !cur && prev);
  endfunction
endpackage

// File: rtl/cct_edge_sync.sv
module cct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] sel,
  output logic       edge_o,
  output logic       rise_o
);
  import cct_pkg::*;

  logic [STAGES-1:0] sh;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sh[STAGES-1];
  end

  assign edge_o = edge_hit(sel, sh[STAGES-1], prev);
  assign rise_o = edge_hit(EDGE_RISE, sh[STAGES-1], prev);

  // R9: a single level change yields one detection only
  p_single_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         match,
  input  logic         cap_clr,
  input  logic         stop_on_match,
  output logic [W-1:0] cnt,
  output logic         done
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] inc(input logic [W-1:0] v);
    return v + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (cap_clr) begin
      cnt <= '0;
    end else if (match) begin
      cnt  <= '0;
      done <= stop_on_match;
    end else if (tick && !done) begin
      cnt <= inc(cnt);
    end
  end

  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
  p_clear_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cnt == '0));
  p_oneshot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && done) |=> (cnt == '0));
  p_pw_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_clr |=> (cnt == '0));
endmodule

// File: rtl/cct_ccreg.sv
module cct_ccreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         cap_role,
  input  logic         batch,
  input  logic [W-1:0] cnt,
  input  logic         cap_evt,
  input  logic         clr_evt,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ccr,
  output logic [W-1:0] cmp_buf,
  output logic         arm
);
  logic wr_ccr, wr_arm, reload;

  assign wr_ccr = wr_en && !wr_sel;
  assign wr_arm = wr_en && wr_sel;
  assign reload = en && !cap_role && clr_evt && (!batch || arm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccr <= '0;
    end else if (cap_role) begin
      if (!en)          ccr <= '0;
      else if (cap_evt) ccr <= cnt;
    end else if (wr_ccr) begin
      ccr <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_buf <= '0;
    end else if (!cap_role) begin
      if (!en && wr_ccr) cmp_buf <= wr_data;
      else if (reload)   cmp_buf <= ccr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en || !batch) begin
      arm <= 1'b0;
    end else begin
      if (clr_evt) arm <= 1'b0;
      if (wr_arm)  arm <= 1'b1;
    end
  end

  p_cap_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_role && !en) |=> (ccr == '0));
  p_keep_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_role && !en && !wr_ccr) |=> $stable(ccr));
  p_batch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && batch && !cap_role && !arm) |=> $stable(cmp_buf));
  p_stopped_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cap_role && wr_ccr) |=> (cmp_buf == $past(wr_data)));
  p_wr_ignored_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_role && en && !cap_evt) |=> $stable(ccr));
endmodule

// File: rtl/cct_timer.sv
module cct_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_en,
  input  logic [2:0]       mode,
  input  logic             cyc_tick,
  input  logic             evt_in,
  input  logic             cap_in,
  input  logic [1:0]       cap_edge_sel,
  input  logic             out_en,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] count_q,
  output logic             cmp_irq,
  output logic             cap_irq,
  output logic             tmr_out
);
  import cct_pkg::*;

  logic cap_role, batch, evt_rise, evt_edge_unused, cap_edge, cap_rise_unused;
  logic tick, match, cap_evt, cap_clr, done, arm;
  logic [CNT_W-1:0] cnt, ccr, cmp_buf;

  assign cap_role = is_capture(mode);
  assign batch    = is_batch(mode);

  cct_edge_sync #(.STAGES(SYNC_STAGES)) u_evt (
    .clk(clk), .rst_n(rst_n), .din(evt_in), .sel(EDGE_RISE),
    .edge_o(evt_edge_unused), .rise_o(evt_rise));

  cct_edge_sync #(.STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .din(cap_in), .sel(cap_edge_sel),
    .edge_o(cap_edge), .rise_o(cap_rise_unused));

  assign tick    = (mode == MODE_EVENT) ? evt_rise : cyc_tick;
  assign match   = tmr_en && !cap_role && tick && !done && (cnt == cmp_buf);
  assign cap_evt = tmr_en && cap_role && cap_edge;
  assign cap_clr = cap_evt && (mode == MODE_PWIDTH);

  cct_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .tick(tick), .match(match),
    .cap_clr(cap_clr), .stop_on_match(mode == MODE_ONESHOT),
    .cnt(cnt), .done(done));

  cct_ccreg #(.W(CNT_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .cap_role(cap_role), .batch(batch),
    .cnt(cnt), .cap_evt(cap_evt), .clr_evt(match), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .ccr(ccr), .cmp_buf(cmp_buf), .arm(arm));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_irq <= 1'b0;
      cap_irq <= 1'b0;
      tmr_out <= 1'b0;
    end else begin
      cmp_irq <= match;
      cap_irq <= cap_evt;
      if (match && out_en) tmr_out <= !tmr_out;
    end
  end

  assign rd_data = ccr;
  assign count_q = cnt;

  p_irq_after_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> cmp_irq);
  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (match && out_en) |=> (tmr_out != $past(tmr_out)));
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(match && out_en) |=> $stable(tmr_out));
  p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_irq && rd_data == $past(cnt)));
  p_arm_batch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> batch);
endmodule

// File: tb/sim_cct_timer.sv
module sim_cct_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_en = 1'b0, cyc_tick = 1'b0, evt_in = 1'b0, cap_in = 1'b0;
  logic out_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [1:0] cap_edge_sel = 2'b01;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, count_q;
  logic cmp_irq, cap_irq, tmr_out;
  int n_checks = 0, n_fail = 0;
  logic finished = 1'b0;

  always #5 clk = !clk;

  cct_timer #(.CNT_W(16), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .mode(mode), .cyc_tick(cyc_tick),
    .evt_in(evt_in), .cap_in(cap_in), .cap_edge_sel(cap_edge_sel), .out_en(out_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_data(rd_data),
    .count_q(count_q), .cmp_irq(cmp_irq), .cap_irq(cap_irq), .tmr_out(tmr_out));

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tmr_en = 0; cyc_tick = 1; evt_in = 0; cap_in = 0; out_en = 0;
    wr_en = 0; wr_sel = 0; wr_data = '0; mode = 3'd0; cap_edge_sel = 2'b01;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic write(input logic sel, input logic [15:0] v);
    wr_en = 1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 0; wr_sel = 0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cmp_irq && n < 200);
  endtask

  task automatic do_cap(input logic lvl, output int exp);
    cap_in = lvl;
    @(negedge clk);
    @(negedge clk);
    exp = count_q;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", count_q, 0); chk("R1 rd", rd_data, 0);
    chk("R1 irq", cmp_irq | cap_irq, 0); chk("R1 out", tmr_out, 0);
  endtask

  task automatic t_interval();
    int n; logic o;
    do_reset();
    mode = 3'd0; out_en = 1;
    write(0, 16'd4);
    chk("R4 write stopped rd", rd_data, 4);
    chk("R4 held zero", count_q, 0);
    tmr_en = 1;
    wait_irq(n);
    chk("R2 cleared at match", count_q, 0);
    o = tmr_out;
    chk("R3 toggled", o, 1);
    wait_irq(n);
    chk("R2 period B+1", n, 5);
    chk("R3 toggle again", tmr_out, !o);
    @(negedge clk); chk("R3 one-cycle pulse", cmp_irq, 0);
    write(0, 16'd7);
    chk("R5 rd updates at once", rd_data, 7);
    wait_irq(n);
    chk("R5 old buffer still used", n, 3);
    wait_irq(n);
    chk("R5 reload at clear", n, 8);
    out_en = 0; o = tmr_out;
    wait_irq(n);
    chk("R3 no toggle when disabled", tmr_out, o);
    tmr_en = 0;
    @(negedge clk);
    chk("R4 disable holds zero", count_q, 0);
    chk("R12 compare kept", rd_data, 7);
  endtask

  task automatic t_batch();
    int n;
    do_reset();
    mode = 3'd4;
    write(0, 16'd4);
    tmr_en = 1;
    wait_irq(n);
    write(0, 16'd9);
    wait_irq(n);
    chk("R6 first period", n, 4);
    wait_irq(n);
    chk("R6 no reload without arm", n, 5);
    write(1, 16'd0);
    wait_irq(n);
    chk("R6 armed period old", n, 4);
    wait_irq(n);
    chk("R6 reload after arm", n, 10);
    write(0, 16'd2);
    wait_irq(n);
    chk("R6 arm consumed a", n, 9);
    wait_irq(n);
    chk("R6 arm consumed b", n, 10);
  endtask

  task automatic pulse_evt(inout int irqs);
    evt_in = 1;
    repeat (3) begin @(negedge clk); if (cmp_irq) irqs++; end
    evt_in = 0;
    repeat (4) begin @(negedge clk); if (cmp_irq) irqs++; end
  endtask

  task automatic t_event();
    int irqs = 0;
    do_reset();
    mode = 3'd1; cyc_tick = 1;
    write(0, 16'd2);
    tmr_en = 1;
    pulse_evt(irqs);
    chk("R7 one edge one count", count_q, 1);
    repeat (10) @(negedge clk);
    chk("R7 cyc_tick ignored", count_q, 1);
    pulse_evt(irqs);
    chk("R7 second edge", count_q, 2);
    pulse_evt(irqs);
    chk("R7 match on third edge", irqs, 1);
    chk("R2 event period clear", count_q, 0);
  endtask

  task automatic t_oneshot();
    int irqs = 0;
    do_reset();
    mode = 3'd3;
    write(0, 16'd3);
    tmr_en = 1;
    repeat (30) begin @(negedge clk); if (cmp_irq) irqs++; end
    chk("R8 single match", irqs, 1);
    chk("R8 counter stopped", count_q, 0);
    tmr_en = 0; @(negedge clk); tmr_en = 1;
    irqs = 0;
    repeat (10) begin @(negedge clk); if (cmp_irq) irqs++; end
    chk("R8 restart after re-enable", irqs, 1);
  endtask

  task automatic t_freerun();
    int exp, seen;
    do_reset();
    mode = 3'd5; cap_edge_sel = 2'b01;
    tmr_en = 1;
    repeat (20) @(negedge clk);
    do_cap(1, exp);
    chk("R10 captured count", rd_data, exp);
    chk("R10 cap_irq", cap_irq, 1);
    chk("R10 counter undisturbed", count_q, exp + 1);
    @(negedge clk);
    chk("R10 cap_irq one cycle", cap_irq, 0);
    seen = 0;
    cap_in = 0;
    repeat (6) begin @(negedge clk); if (cap_irq) seen++; end
    chk("R9 falling ignored under rising select", seen, 0);
    chk("R13 rd stable", rd_data, exp);
    write(0, 16'h1234);
    chk("R13 write ignored", rd_data, exp);
    cap_edge_sel = 2'b10;
    seen = 0;
    cap_in = 1;
    repeat (6) begin @(negedge clk); if (cap_irq) seen++; end
    chk("R9 rising ignored under falling select", seen, 0);
    do_cap(0, exp);
    chk("R9 falling captured", rd_data, exp);
    cap_edge_sel = 2'b00;
    seen = 0;
    cap_in = 1;
    repeat (6) begin @(negedge clk); if (cap_irq) seen++; end
    chk("R9 none select", seen, 0);
    tmr_en = 0;
    @(negedge clk);
    chk("R12 capture cleared on disable", rd_data, 0);
  endtask

  task automatic t_pwidth();
    int exp;
    do_reset();
    mode = 3'd6; cap_edge_sel = 2'b11;
    tmr_en = 1;
    repeat (10) @(negedge clk);
    do_cap(1, exp);
    chk("R11 captured", rd_data, exp);
    chk("R11 counter cleared", count_q, 0);
    repeat (6) @(negedge clk);
    do_cap(0, exp);
    chk("R11 second width", exp, 8);
    chk("R11 both edges capture", rd_data, 8);
  endtask

  initial begin
    t_reset();
    t_interval();
    t_batch();
    t_event();
    t_oneshot();
    t_freerun();
    t_pwidth();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule